// File: doc/BRIEF.md
# Strided IDE Register Window Decoder

This block sits between a memory-mapped bus and the register model of a parallel ATA channel. It maps a 4 KB address window onto that channel's registers. Registers sit one every 16 bytes. The bus supplies an address, an access size (byte, halfword or word), a write flag and write data. The block works out which device register, if any, the access targets. For every access that reaches a register, it raises a one-cycle strobe toward the task-file model, together with a register index, a direction flag, a width flag and the write data.

Byte accesses reach the seven task-file registers and the device control register. The control register can be reached through either of two aliased slots. A read through either slot returns the alternate status register instead. Halfword and word accesses reach only the data port, and the data port reverses byte order in both directions. An access that hits nothing is absorbed: a write disappears without a strobe, and a read still completes, with all ones of the requested width.

Reads take a fixed two cycles from request to result. In the first cycle the strobe goes downstream. The device answers during the strobe cycle, and the answer, or the fill value for an unmapped read, appears on the bus one cycle later with a valid pulse. A new request may be issued on every cycle.

Top module: `ide_stride_decoder`

## Requirements
- R1: Only address bits [11:0] take part in decoding. Changing any address bit above bit 11 never changes the strobe, the index or the returned data. Bits [3:0] are also ignored.
- R2: A byte access whose slot (address bits [11:4]) is 1 to 7 raises dev_stb with dev_idx equal to the slot and dev_we equal to the request's write flag.
- R3: A byte access to slot 8 or slot 22 raises dev_stb with dev_idx = 8. A write there targets the control register, and a read there returns alternate status.
- R4: A byte access to any other slot raises no strobe. A read there returns 0x000000FF.
- R5: bus_size encodes 0 = byte, 1 = halfword, 2 = word and 3 = reserved. A halfword or word access to slot 0 raises dev_stb with dev_idx = 0. Any other halfword or word access, and every reserved-size access, raises no strobe. Such reads return 0x0000FFFF for a halfword and 0xFFFFFFFF for a word or a reserved size.
- R6: dev_wdata presents the write data as follows:
  - a byte write: {24'b0, wdata[7:0]};
  - a halfword write: {16'b0, wdata[7:0], wdata[15:8]};
  - a word write: the four bytes of wdata in reversed order.
- R7: A mapped read returns dev_rdata as follows:
  - a byte read: {24'b0, dev_rdata[7:0]};
  - a halfword read: the 16-bit byte swap of dev_rdata[15:0], zero-extended;
  - a word read: the 32-bit byte swap of dev_rdata.
- R8: A request sampled at clock edge N produces dev_stb (if the access is mapped) for exactly the cycle after edge N. A read produces bus_rvalid for exactly the cycle after edge N+1. A write never produces bus_rvalid.
- R9: A word access to the data port produces a single strobe with dev_wide = 1. A halfword access produces dev_wide = 0.
- R10: While rst_n is low, dev_stb, bus_rvalid and bus_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address; only the low 12 bits decode |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read result, right-aligned |
| bus_rvalid | output | 1 | One-cycle read completion pulse |
| dev_stb | output | 1 | One-cycle register access strobe |
| dev_we | output | 1 | Direction of the strobed access |
| dev_wide | output | 1 | 1 for a 32-bit data-port transfer |
| dev_idx | output | 4 | Register index: 0 data, 1 to 7 task file, 8 control/alt status |
| dev_wdata | output | 32 | Byte-ordered write data for the device |
| dev_rdata | input | 32 | Device read data, valid during the strobe cycle |

## Verification
The hardest case to reach from the ports is a continuous stream of requests in which reads, writes, unmapped accesses and both control aliases follow one another on every cycle. In that case a read's result is still in flight while the next strobe goes out, and an unmapped read must not disturb the strobe pipeline. The stimulus gets there with a long stretch of back-to-back random requests drawn mostly from the mapped slots and the two aliases. Random upper address bits are applied on top of those requests. The reference model is checked every cycle, which covers both the strobe pipeline and the read-result pipeline under that overlap.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

   // access size encoding on the bus side
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // downstream register index width: data, seven task-file slots, control
   localparam int IDX_W = 4;

   typedef struct packed {
      logic             hit;
      logic             wide;
      logic [IDX_W-1:0] idx;
   } dec_t;

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
   import ide_win_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int WIN_BITS     = 12,
   parameter int STRIDE_SHIFT = 4,
   parameter int TF_FIRST     = 1,
   parameter int TF_LAST      = 7,
   parameter int CTRL_SLOT_A  = 8,
   parameter int CTRL_SLOT_B  = 22,
   parameter int CTRL_IDX     = 8,
   parameter int DATA_SLOT    = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   output dec_t              dec
);

   localparam int SLOT_W = WIN_BITS - STRIDE_SHIFT;
   localparam logic [SLOT_W-1:0] S_TF_LO  = SLOT_W'(TF_FIRST);
   localparam logic [SLOT_W-1:0] S_TF_HI  = SLOT_W'(TF_LAST);
   localparam logic [SLOT_W-1:0] S_CTRL_A = SLOT_W'(CTRL_SLOT_A);
   localparam logic [SLOT_W-1:0] S_CTRL_B = SLOT_W'(CTRL_SLOT_B);
   localparam logic [SLOT_W-1:0] S_DATA   = SLOT_W'(DATA_SLOT);

   if (SLOT_W < 1) begin : g_bad_window
      $error("window must be wider than the register stride");
   end
   if (CTRL_SLOT_A >= (1 << SLOT_W) || CTRL_SLOT_B >= (1 << SLOT_W)) begin : g_bad_alias
      $error("control alias slot outside the window");
   end
   if (TF_FIRST > TF_LAST || TF_LAST >= CTRL_IDX) begin : g_bad_tf
      $error("task-file range must sit below the control index");
   end

   logic [SLOT_W-1:0] slot;
   assign slot = addr[WIN_BITS-1:STRIDE_SHIFT];

   // bits above the window and inside one stride take no part in decoding
   logic unused_addr_bits;
   assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_BITS], addr[STRIDE_SHIFT-1:0]};

   always_comb begin
      dec = '0;
      case (size)
         SZ_BYTE: begin
            if (slot >= S_TF_LO && slot <= S_TF_HI) begin
               dec.hit = 1'b1;
               dec.idx = IDX_W'(slot);
            end else if (slot == S_CTRL_A || slot == S_CTRL_B) begin
               dec.hit = 1'b1;
               dec.idx = IDX_W'(CTRL_IDX);
            end
         end
         SZ_HALF, SZ_WORD: begin
            if (slot == S_DATA) begin
               dec.hit  = 1'b1;
               dec.wide = (size == SZ_WORD);
               dec.idx  = '0;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap
   import ide_win_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic [BYTE_W*LANES-1:0] din,
   input  acc_size_e               size,
   output logic [BYTE_W*LANES-1:0] dout
);

   localparam int DATA_W = BYTE_W * LANES;
   localparam int HALF_L = 2;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("lane count must be even and at least two");
   end

   logic [BYTE_W*HALF_L-1:0] half_sw;
   logic [DATA_W-1:0]        full_sw;

   for (genvar k = 0; k < HALF_L; k++) begin : g_half
      assign half_sw[k*BYTE_W +: BYTE_W] = din[(HALF_L-1-k)*BYTE_W +: BYTE_W];
   end
   for (genvar k = 0; k < LANES; k++) begin : g_full
      assign full_sw[k*BYTE_W +: BYTE_W] = din[(LANES-1-k)*BYTE_W +: BYTE_W];
   end

   always_comb begin
      dout = '0;
      case (size)
         SZ_BYTE: dout[BYTE_W-1:0]        = din[BYTE_W-1:0];
         SZ_HALF: dout[BYTE_W*HALF_L-1:0] = half_sw;
         default: dout                    = full_sw;
      endcase
   end

endmodule

// File: rtl/ide_win_resp.sv
module ide_win_resp
   import ide_win_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    hit,
   input  acc_size_e               size,
   input  logic [BYTE_W*LANES-1:0] swapped,
   output logic [BYTE_W*LANES-1:0] dout
);

   localparam int DATA_W = BYTE_W * LANES;

   logic [DATA_W-1:0] fill;

   always_comb begin
      fill = '0;
      case (size)
         SZ_BYTE: fill[BYTE_W-1:0]   = '1;
         SZ_HALF: fill[2*BYTE_W-1:0] = '1;
         default: fill               = '1;
      endcase
   end

   assign dout = hit ? swapped : fill;

endmodule

// File: rtl/ide_stride_decoder.sv
module ide_stride_decoder
   import ide_win_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int WIN_BITS     = 12,
   parameter int STRIDE_SHIFT = 4,
   parameter int BYTE_W       = 8,
   parameter int LANES        = 4,
   parameter int TF_FIRST     = 1,
   parameter int TF_LAST      = 7,
   parameter int CTRL_SLOT_A  = 8,
   parameter int CTRL_SLOT_B  = 22,
   parameter int CTRL_IDX     = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [1:0]              bus_size,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [BYTE_W*LANES-1:0] bus_wdata,
   output logic [BYTE_W*LANES-1:0] bus_rdata,
   output logic                    bus_rvalid,
   output logic                    dev_stb,
   output logic                    dev_we,
   output logic                    dev_wide,
   output logic [IDX_W-1:0]        dev_idx,
   output logic [BYTE_W*LANES-1:0] dev_wdata,
   input  logic [BYTE_W*LANES-1:0] dev_rdata
);

   localparam int DATA_W = BYTE_W * LANES;

   if (ADDR_W <= WIN_BITS || STRIDE_SHIFT < 1) begin : g_bad_addr
      $error("address must exceed the window and stride must be nonzero");
   end
   if (CTRL_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("control index does not fit the index port");
   end

   acc_size_e sz;
   assign sz = acc_size_e'(bus_size);

   dec_t dec;

   ide_win_decode #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_SHIFT(STRIDE_SHIFT),
      .TF_FIRST(TF_FIRST), .TF_LAST(TF_LAST),
      .CTRL_SLOT_A(CTRL_SLOT_A), .CTRL_SLOT_B(CTRL_SLOT_B),
      .CTRL_IDX(CTRL_IDX), .DATA_SLOT(0)
   ) u_dec (
      .addr(bus_addr), .size(sz), .dec(dec)
   );

   // write data toward the device
   logic [DATA_W-1:0] wr_sw;
   ide_win_swap #(.BYTE_W(BYTE_W), .LANES(LANES)) u_wswap (
      .din(bus_wdata), .size(sz), .dout(wr_sw)
   );

   // read-stage state: one read may be in flight per cycle
   logic      rd_pend;
   logic      rd_hit;
   acc_size_e rd_size;

   logic [DATA_W-1:0] rd_sw;
   logic [DATA_W-1:0] rd_resp;

   ide_win_swap #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rswap (
      .din(dev_rdata), .size(rd_size), .dout(rd_sw)
   );

   ide_win_resp #(.BYTE_W(BYTE_W), .LANES(LANES)) u_resp (
      .hit(rd_hit), .size(rd_size), .swapped(rd_sw), .dout(rd_resp)
   );

   logic acc_hit;
   logic acc_rd;
   assign acc_hit = bus_req && dec.hit;
   assign acc_rd  = bus_req && !bus_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_stb    <= 1'b0;
         dev_we     <= 1'b0;
         dev_wide   <= 1'b0;
         dev_idx    <= '0;
         dev_wdata  <= '0;
         rd_pend    <= 1'b0;
         rd_hit     <= 1'b0;
         rd_size    <= SZ_BYTE;
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         dev_stb <= acc_hit;
         if (acc_hit) begin
            dev_we    <= bus_we;
            dev_wide  <= dec.wide;
            dev_idx   <= dec.idx;
            dev_wdata <= bus_we ? wr_sw : '0;
         end
         rd_pend <= acc_rd;
         if (acc_rd) begin
            rd_hit  <= dec.hit;
            rd_size <= sz;
         end
         bus_rvalid <= rd_pend;
         if (rd_pend) begin
            bus_rdata <= rd_resp;
         end
      end
   end

   // R8: a strobe only ever follows a sampled request
   a_r8_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      dev_stb |-> $past(bus_req));

   // R8: read completion two edges after a read request
   a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_req && !bus_we, 2));

   // R8: a write strobe is never answered with read data
   a_r8_no_rvalid_for_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> !$past(dev_stb && dev_we));

   // R2: strobed indices stay within the register set
   a_r2_idx_legal: assert property (@(posedge clk) disable iff (!rst_n)
      dev_stb |-> (dev_idx <= IDX_W'(CTRL_IDX)));

   // R9: a 32-bit transfer only targets the data port
   a_r9_wide_data_only: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_stb && dev_wide) |-> (dev_idx == '0));

   // R4 / R5: a read with no preceding strobe returns fill ones
   a_r5_unmapped_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && !$past(dev_stb)) |-> (bus_rdata[BYTE_W-1:0] == '1));

endmodule

// File: tb/sim_ide_stride_decoder.sv
module sim_ide_stride_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_size = 2'd0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        dev_stb, dev_we, dev_wide;
   logic [3:0]  dev_idx;
   logic [31:0] dev_wdata;
   logic [31:0] dev_rdata;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #4 clk = ~clk;   // 125 MHz

   function automatic logic [31:0] devval(input logic [3:0] idx);
      return 32'hC3A5_1E00 + {28'b0, idx} * 32'h0101_0107;
   endfunction

   assign dev_rdata = devval(dev_idx);

   ide_stride_decoder u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .dev_stb(dev_stb),
      .dev_we(dev_we), .dev_wide(dev_wide), .dev_idx(dev_idx),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   function automatic logic [31:0] order(input logic [31:0] d, input logic [1:0] sz);
      if (sz == 2'd0) return {24'b0, d[7:0]};
      if (sz == 2'd1) return {16'b0, d[7:0], d[15:8]};
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   function automatic logic [31:0] fillv(input logic [1:0] sz);
      if (sz == 2'd0) return 32'h0000_00FF;
      if (sz == 2'd1) return 32'h0000_FFFF;
      return 32'hFFFF_FFFF;
   endfunction

   // behavioural reference: decode from the requirements
   function automatic logic [5:0] bdec(input logic [31:0] a, input logic [1:0] sz);
      int s;
      s = int'(a[11:4]);
      if (sz == 2'd0) begin
         if (s >= 1 && s <= 7) return {1'b1, 1'b0, 4'(s)};
         if (s == 8 || s == 22) return {1'b1, 1'b0, 4'd8};
         return 6'd0;
      end
      if ((sz == 2'd1 || sz == 2'd2) && s == 0) return {1'b1, (sz == 2'd2), 4'd0};
      return 6'd0;
   endfunction

   logic        m_stb = 0, m_we = 0, m_wide = 0;
   logic [3:0]  m_idx = 0;
   logic [31:0] m_wdata = 0;
   string       t_stb = "R8", t_idx = "R2";
   logic        p_rd = 0, p_hit = 0;
   logic [1:0]  p_sz = 0;
   logic [3:0]  p_idx = 0;
   logic        m_rv = 0;
   logic [31:0] m_rdata = 0;
   string       t_rd = "R7";

   always @(posedge clk) begin : model
      logic [5:0] d;
      if (!rst_n) begin
         m_stb <= 0; p_rd <= 0; m_rv <= 0;
      end else begin
         d = bdec(bus_addr, bus_size);
         m_stb <= bus_req && d[5];
         if (!bus_req || d[5]) t_stb <= "R8";
         else t_stb <= (bus_size == 2'd0) ? "R4" : "R5";
         if (bus_req && d[5]) begin
            m_we    <= bus_we;
            m_wide  <= d[4];
            m_idx   <= d[3:0];
            m_wdata <= bus_we ? order(bus_wdata, bus_size) : 32'h0;
            if (bus_addr[31:12] != 0) t_idx <= "R1";
            else if (d[3:0] == 4'd8) t_idx <= "R3";
            else if (d[3:0] == 4'd0) t_idx <= "R5";
            else t_idx <= "R2";
         end
         p_rd <= bus_req && !bus_we;
         if (bus_req && !bus_we) begin
            p_hit <= d[5]; p_sz <= bus_size; p_idx <= d[3:0];
         end
         m_rv <= p_rd;
         if (p_rd) begin
            m_rdata <= p_hit ? order(devval(p_idx), p_sz) : fillv(p_sz);
            t_rd <= p_hit ? "R7" : ((p_sz == 2'd0) ? "R4" : "R5");
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string tag, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk({31'b0, dev_stb}, {31'b0, m_stb}, t_stb, "dev_stb");
         if (m_stb) begin
            chk({28'b0, dev_idx}, {28'b0, m_idx}, t_idx, "dev_idx");
            chk({31'b0, dev_we}, {31'b0, m_we}, "R2", "dev_we");
            chk({31'b0, dev_wide}, {31'b0, m_wide}, "R9", "dev_wide");
            if (m_we) chk(dev_wdata, m_wdata, "R6", "dev_wdata");
         end
         chk({31'b0, bus_rvalid}, {31'b0, m_rv}, "R8", "bus_rvalid");
         if (m_rv) chk(bus_rdata, m_rdata, t_rd, "bus_rdata");
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         failures++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_req = 1'b0;
      end
   endtask

   initial begin
      // R10: outputs held at zero through reset, even with a request pending
      bus_req = 1'b1; bus_addr = 32'h10; bus_size = 2'd0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk({31'b0, dev_stb}, 32'h0, "R10", "reset dev_stb");
         chk({31'b0, bus_rvalid}, 32'h0, "R10", "reset bus_rvalid");
         chk(bus_rdata, 32'h0, "R10", "reset bus_rdata");
      end
      bus_req = 1'b0;
      rst_n = 1'b1;
      idle(2);

      // every slot, byte write and byte read (R2, R3, R4)
      for (int s = 0; s < 256; s++) begin
         acc(1'b1, 2'd0, {20'h0, 8'(s), 4'($urandom)}, $urandom);
         acc(1'b0, 2'd0, {20'h0, 8'(s), 4'($urandom)}, 32'h0);
      end
      idle(3);

      // data port and its misses (R5, R6, R7, R9)
      for (int sz = 1; sz < 4; sz++) begin
         for (int s = 0; s < 256; s += 17) begin
            acc(1'b1, 2'(sz), {20'h0, 8'(s), 4'h0}, 32'h1122_3344 + 32'(s));
            idle(1);
            acc(1'b0, 2'(sz), {20'h0, 8'(s), 4'h0}, 32'h0);
            idle(2);
         end
      end

      // control aliases under high address bits (R1, R3)
      acc(1'b1, 2'd0, 32'hFFFF_F080, 32'h0000_00A5);
      acc(1'b0, 2'd0, 32'h1234_5160, 32'h0);
      acc(1'b0, 2'd2, 32'hABCD_E000, 32'h0);
      acc(1'b1, 2'd2, 32'h8000_0007, 32'hDEAD_BEEF);
      idle(3);

      // back-to-back mixed stream (R8 overlap)
      for (int n = 0; n < 4000; n++) begin
         logic [7:0]  s;
         logic [1:0]  sz;
         int          pick;
         pick = int'($urandom_range(0, 9));
         if (pick < 5) s = 8'($urandom_range(1, 7));
         else if (pick == 5) s = 8'd8;
         else if (pick == 6) s = 8'd22;
         else if (pick == 7) s = 8'd0;
         else s = 8'($urandom);
         sz = (s == 0) ? 2'($urandom_range(0, 3)) : ((pick == 9) ? 2'($urandom) : 2'd0);
         acc(1'($urandom), sz, {($urandom & 32'hFFFFF) << 12 | {20'h0, s, 4'($urandom)}},
             $urandom);
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      idle(4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule